// File: doc/BRIEF.md
# Watchdog-aware timer status register

This block keeps, for every hardware thread, a small status word that records timer events. Three event sources (a decrementer, a user decrementer and a fixed-interval timer) each have one sticky flag. A fourth source, a watchdog timeout, escalates through three stages. The first timeout arms the next stage. The second timeout raises an interrupt status. The third timeout asks the reset logic for a reset of a configured kind and records that kind.

Hardware is the only agent that can set a flag, and software is the only agent that can clear one. A software write carries a clear mask. A 1 in the mask clears the matching flag and a 0 leaves it as it is. Software selects one thread through a shared port, which serves both for reading the word and for writing a mask. The watchdog interrupt request and the reset request leave the block per thread. The timers, the privilege checks and the reset sequencer are outside this block.

Top module: `tsr_bank`

## Requirements
- R1: After reset every flag of every thread is 0, `rd_data` reads 0, and `wdog_irq`, `wdog_rst_req` and `wdog_rst_kind` are all 0.
- R2: `rd_data` shows the thread picked by `sw_sel`, with bits numbered from 0 at the LSB. Bit 31 is the watchdog arm flag, bit 30 the watchdog interrupt status, bits 29:28 the recorded reset kind, bit 27 the decrementer flag, bit 26 the fixed-interval flag and bit 25 the user-decrementer flag. Every other bit reads 0.
- R3: A one-cycle pulse on `evt_dec`, `evt_fit` or `evt_udec` sets the thread's matching flag on the next clock edge, and the flag then stays 1 until software clears it.
- R4: When `sw_wr` is 1, each 1 in `sw_clr_mask` clears the matching flag of the selected thread at the next edge and each 0 leaves it unchanged. A write never sets a flag, including bits that read as 0.
- R5: A watchdog pulse while the arm flag is 0 sets the arm flag and changes nothing else.
- R6: A watchdog pulse while the arm flag is 1 and the interrupt status is 0 sets the interrupt status and changes nothing else.
- R7: A watchdog pulse while both the arm flag and the interrupt status are 1, with `wdog_rst_cfg` not equal to 00, drives `wdog_rst_req` high for exactly one cycle after the edge, with `wdog_rst_kind` equal to that configuration. The reset-kind field takes this value only if the field was 00. With configuration 00 (no reset) the pulse raises no request and records nothing.
- R8: `wdog_irq` is 1 exactly when the interrupt status is 1, `wdog_irq_en` is 1 and at least one of `crit_en` or `guest_en` is 1.
- R9: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends at 1.
- R10: Events, writes and configuration inputs of one thread leave the flags and outputs of every other thread unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_dec | input | NT | Decrementer event pulse, one bit per thread |
| evt_udec | input | NT | User-decrementer event pulse, one bit per thread |
| evt_fit | input | NT | Fixed-interval timer event pulse, one bit per thread |
| evt_wdog | input | NT | Watchdog timeout pulse, one bit per thread |
| sw_sel | input | TID_W | Thread selected for read and write |
| sw_wr | input | 1 | Apply the clear mask to the selected thread |
| sw_clr_mask | input | 64 | Clear mask: 1 clears, 0 keeps |
| rd_data | output | 64 | Status word of the selected thread |
| wdog_irq_en | input | NT | Watchdog interrupt enable per thread |
| crit_en | input | NT | Critical-interrupt enable per thread |
| guest_en | input | NT | Guest-state bit per thread |
| wdog_rst_cfg | input | 2*NT | Configured reset kind per thread (00 means none) |
| wdog_irq | output | NT | Watchdog interrupt request per thread |
| wdog_rst_req | output | NT | One-cycle watchdog reset request per thread |
| wdog_rst_kind | output | 2*NT | Reset kind that goes with the request |

## Verification
A wrong internal state shows on `rd_data` one cycle after the event or write that caused it, as soon as the affected thread is selected. A watchdog stage that has gone wrong also shows on the request outputs. A skipped or repeated stage moves the reset pulse one timeout earlier or later. A wrong interrupt status shows on `wdog_irq` in the same cycle as the status bit. The bench walks every watchdog stage, both enable paths of the interrupt, the "no reset" kind, a repeated reset with a different kind, and same-cycle set/clear collisions. After each step it reads both threads so that leakage between threads is caught.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int REG_W = 64;

    // Bit positions inside the 64-bit word (LSB = 0); software decodes these.
    localparam int POS_ARM  = 31;
    localparam int POS_IRQ  = 30;
    localparam int POS_RKH  = 29;
    localparam int POS_RKL  = 28;
    localparam int POS_DEC  = 27;
    localparam int POS_FIT  = 26;
    localparam int POS_UDEC = 25;

    typedef struct packed {
        logic       arm;
        logic       irq_st;
        logic [1:0] rkind;
        logic       dec;
        logic       fit;
        logic       udec;
    } tsr_flags_t;

    localparam int FLAG_W = $bits(tsr_flags_t);

    typedef struct packed {
        tsr_flags_t flags;
        logic       rst_req;
        logic [1:0] rst_kind;
    } tsr_slice_state_t;

    function automatic logic [REG_W-1:0] flags_to_word(input tsr_flags_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_ARM]         = f.arm;
        w[POS_IRQ]         = f.irq_st;
        w[POS_RKH:POS_RKL] = f.rkind;
        w[POS_DEC]         = f.dec;
        w[POS_FIT]         = f.fit;
        w[POS_UDEC]        = f.udec;
        return w;
    endfunction

    function automatic tsr_flags_t word_to_flags(input logic [REG_W-1:0] w);
        tsr_flags_t f;
        f.arm    = w[POS_ARM];
        f.irq_st = w[POS_IRQ];
        f.rkind  = w[POS_RKH:POS_RKL];
        f.dec    = w[POS_DEC];
        f.fit    = w[POS_FIT];
        f.udec   = w[POS_UDEC];
        return f;
    endfunction

endpackage

// File: rtl/tsr_slice.sv
module tsr_slice
    import tsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_dec,
    input  logic             ev_udec,
    input  logic             ev_fit,
    input  logic             ev_wdog,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [1:0]       rst_cfg,
    input  logic             irq_en,
    input  logic             crit_en,
    input  logic             guest_en,
    output tsr_flags_t       flags,
    output logic             irq,
    output logic             rst_req,
    output logic [1:0]       rst_kind
);

    tsr_slice_state_t st_d, st_q;
    tsr_flags_t       set_v, clr_v;
    logic             fire, record;

    always_comb begin
        st_d   = st_q;
        set_v  = '0;
        clr_v  = clr_en ? word_to_flags(clr_mask) : '0;
        fire   = 1'b0;
        record = 1'b0;

        set_v.dec  = ev_dec;
        set_v.fit  = ev_fit;
        set_v.udec = ev_udec;

        // Watchdog escalation: arm -> interrupt status -> reset
        if (ev_wdog) begin
            if (!st_q.flags.arm) begin
                set_v.arm = 1'b1;
            end else if (!st_q.flags.irq_st) begin
                set_v.irq_st = 1'b1;
            end else if (rst_cfg != 2'b00) begin
                fire   = 1'b1;
                record = (st_q.flags.rkind == 2'b00);
            end
        end
        if (record) begin
            set_v.rkind = rst_cfg;
        end

        // Set wins over clear on the same bit
        st_d.flags    = tsr_flags_t'((st_q.flags & ~clr_v) | set_v);
        st_d.rst_req  = fire;
        st_d.rst_kind = fire ? rst_cfg : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags    = st_q.flags;
    assign irq      = st_q.flags.irq_st & irq_en & (crit_en | guest_en);
    assign rst_req  = st_q.rst_req;
    assign rst_kind = st_q.rst_kind;

endmodule

// File: rtl/tsr_rdmux.sv
module tsr_rdmux
    import tsr_pkg::*;
#(
    parameter int NT    = 2,
    parameter int TID_W = 1
) (
    input  tsr_flags_t [NT-1:0] flags,
    input  logic [TID_W-1:0]    sel,
    output logic [REG_W-1:0]    data
);

    always_comb begin
        data = '0;
        for (int t = 0; t < NT; t++) begin
            if (sel == TID_W'(t)) begin
                data = flags_to_word(flags[t]);
            end
        end
    end

endmodule

// File: rtl/tsr_bank.sv
module tsr_bank
    import tsr_pkg::*;
#(
    parameter int NT    = 2,
    parameter int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT-1:0]        evt_dec,
    input  logic [NT-1:0]        evt_udec,
    input  logic [NT-1:0]        evt_fit,
    input  logic [NT-1:0]        evt_wdog,
    input  logic [TID_W-1:0]     sw_sel,
    input  logic                 sw_wr,
    input  logic [63:0]          sw_clr_mask,
    output logic [63:0]          rd_data,
    input  logic [NT-1:0]        wdog_irq_en,
    input  logic [NT-1:0]        crit_en,
    input  logic [NT-1:0]        guest_en,
    input  logic [NT-1:0][1:0]   wdog_rst_cfg,
    output logic [NT-1:0]        wdog_irq,
    output logic [NT-1:0]        wdog_rst_req,
    output logic [NT-1:0][1:0]   wdog_rst_kind
);

    tsr_flags_t [NT-1:0] thr_st;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic clr_here;
        assign clr_here = sw_wr && (sw_sel == TID_W'(t));

        tsr_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_dec   (evt_dec[t]),
            .ev_udec  (evt_udec[t]),
            .ev_fit   (evt_fit[t]),
            .ev_wdog  (evt_wdog[t]),
            .clr_en   (clr_here),
            .clr_mask (sw_clr_mask),
            .rst_cfg  (wdog_rst_cfg[t]),
            .irq_en   (wdog_irq_en[t]),
            .crit_en  (crit_en[t]),
            .guest_en (guest_en[t]),
            .flags    (thr_st[t]),
            .irq      (wdog_irq[t]),
            .rst_req  (wdog_rst_req[t]),
            .rst_kind (wdog_rst_kind[t])
        );
    end

    tsr_rdmux #(.NT(NT), .TID_W(TID_W)) u_rdmux (
        .flags (thr_st),
        .sel   (sw_sel),
        .data  (rd_data)
    );

endmodule

// File: rtl/tsr_bank_chk.sv
module tsr_bank_chk
    import tsr_pkg::*;
#(
    parameter int NT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NT-1:0]       evt_dec,
    input logic [NT-1:0]       evt_fit,
    input logic [NT-1:0]       evt_udec,
    input logic [NT-1:0]       evt_wdog,
    input logic [NT-1:0]       wdog_irq_en,
    input logic [NT-1:0]       crit_en,
    input logic [NT-1:0]       guest_en,
    input logic [NT-1:0][1:0]  wdog_rst_cfg,
    input logic [NT-1:0]       wdog_irq,
    input logic [NT-1:0]       wdog_rst_req,
    input logic [NT-1:0][1:0]  wdog_rst_kind,
    input tsr_flags_t [NT-1:0] st
);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        // R3 and R9: an event leaves its flag set, whatever a write did
        assert_dec_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_dec[t] |=> st[t].dec);
        assert_fit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt_fit[t] |=> st[t].fit);
        // R4: nothing but an event raises a sticky flag
        assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!st[t].udec && !evt_udec[t]) |=> !st[t].udec);
        // R5: first watchdog stage arms
        assert_wdog_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_wdog[t] && !st[t].arm) |=> (st[t].arm && !wdog_rst_req[t]));
        // R7: a reset request follows a watchdog pulse and carries its kind
        assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_rst_req[t] |-> ($past(evt_wdog[t]) && $past(st[t].irq_st)
                                 && wdog_rst_kind[t] == $past(wdog_rst_cfg[t])
                                 && wdog_rst_kind[t] != 2'b00));
        assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wdog_rst_req[t] && !evt_wdog[t]) |=> !wdog_rst_req[t]);
        // R8: interrupt needs its enables
        assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_irq[t] |-> (wdog_irq_en[t] && (crit_en[t] || guest_en[t])));
    end

endmodule

bind tsr_bank tsr_bank_chk #(.NT(NT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_dec       (evt_dec),
    .evt_fit       (evt_fit),
    .evt_udec      (evt_udec),
    .evt_wdog      (evt_wdog),
    .wdog_irq_en   (wdog_irq_en),
    .crit_en       (crit_en),
    .guest_en      (guest_en),
    .wdog_rst_cfg  (wdog_rst_cfg),
    .wdog_irq      (wdog_irq),
    .wdog_rst_req  (wdog_rst_req),
    .wdog_rst_kind (wdog_rst_kind),
    .st            (thr_st)
);

// File: tb/tsr_bank_bench.sv
module tsr_bank_bench;

    localparam int NT    = 2;
    localparam int TID_W = 1;

    localparam logic [63:0] B_ARM  = 64'h1 << 31;
    localparam logic [63:0] B_IRQ  = 64'h1 << 30;
    localparam logic [63:0] B_DEC  = 64'h1 << 27;
    localparam logic [63:0] B_FIT  = 64'h1 << 26;
    localparam logic [63:0] B_UDEC = 64'h1 << 25;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NT-1:0]      evt_dec = '0, evt_udec = '0, evt_fit = '0, evt_wdog = '0;
    logic [TID_W-1:0]   sw_sel = '0;
    logic               sw_wr = 1'b0;
    logic [63:0]        sw_clr_mask = '0;
    logic [63:0]        rd_data;
    logic [NT-1:0]      wdog_irq_en = '0, crit_en = '0, guest_en = '0;
    logic [NT-1:0][1:0] wdog_rst_cfg = '0;
    logic [NT-1:0]      wdog_irq, wdog_rst_req;
    logic [NT-1:0][1:0] wdog_rst_kind;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    tsr_bank #(.NT(NT)) u_tsr_bank (
        .clk(clk), .rst_n(rst_n),
        .evt_dec(evt_dec), .evt_udec(evt_udec), .evt_fit(evt_fit), .evt_wdog(evt_wdog),
        .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_clr_mask(sw_clr_mask), .rd_data(rd_data),
        .wdog_irq_en(wdog_irq_en), .crit_en(crit_en), .guest_en(guest_en),
        .wdog_rst_cfg(wdog_rst_cfg), .wdog_irq(wdog_irq),
        .wdog_rst_req(wdog_rst_req), .wdog_rst_kind(wdog_rst_kind)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_thr(input int t, output logic [63:0] v);
        sw_sel = TID_W'(t);
        #1;
        v = rd_data;
    endtask

    // Drive at negedge, one edge, back at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        evt_dec = '0; evt_udec = '0; evt_fit = '0; evt_wdog = '0;
        sw_wr = 1'b0; sw_clr_mask = '0;
    endtask

    task automatic clear_thr(input int t, input logic [63:0] m);
        sw_sel = TID_W'(t); sw_wr = 1'b1; sw_clr_mask = m;
        step();
    endtask

    task automatic t_reset();
        logic [63:0] v;
        for (int t = 0; t < NT; t++) begin
            read_thr(t, v);
            check("R1 reset word", v, 64'h0);
        end
        check("R1 reset outputs", {58'h0, wdog_irq, wdog_rst_req, wdog_rst_kind}, 64'h0);
    endtask

    task automatic t_sticky();
        logic [63:0] v;
        evt_dec[0] = 1'b1; step();
        read_thr(0, v); check("R3 R2 dec bit 27", v, B_DEC);
        evt_fit[0] = 1'b1; evt_udec[0] = 1'b1; step();
        repeat (5) step();
        read_thr(0, v); check("R3 R2 sticky fit/udec", v, B_DEC | B_FIT | B_UDEC);
        read_thr(1, v); check("R10 other thread clean", v, 64'h0);
    endtask

    task automatic t_mask();
        logic [63:0] v;
        clear_thr(0, B_FIT);
        read_thr(0, v); check("R4 mask clears one bit", v, B_DEC | B_UDEC);
        clear_thr(1, '1);
        read_thr(1, v); check("R4 write cannot set", v, 64'h0);
        clear_thr(0, ~(B_DEC | B_UDEC));
        read_thr(0, v); check("R4 zeros keep bits", v, B_DEC | B_UDEC);
        clear_thr(0, '1);
        read_thr(0, v); check("R4 full clear", v, 64'h0);
    endtask

    task automatic t_wdog();
        logic [63:0] v;
        wdog_rst_cfg[0] = 2'b10;
        evt_wdog[0] = 1'b1; step();
        read_thr(0, v); check("R5 first timeout arms", v, B_ARM);
        check("R5 no request", {63'h0, wdog_rst_req[0]}, 64'h0);
        evt_wdog[0] = 1'b1; step();
        read_thr(0, v); check("R6 second timeout irq status", v, B_ARM | B_IRQ);
        wdog_irq_en[0] = 1'b1; #1;
        check("R8 no crit/guest", {63'h0, wdog_irq[0]}, 64'h0);
        crit_en[0] = 1'b1; #1;
        check("R8 crit path", {63'h0, wdog_irq[0]}, 64'h1);
        crit_en[0] = 1'b0; guest_en[0] = 1'b1; #1;
        check("R8 guest path", {63'h0, wdog_irq[0]}, 64'h1);
        wdog_irq_en[0] = 1'b0; #1;
        check("R8 enable off", {63'h0, wdog_irq[0]}, 64'h0);
        check("R10 irq other thread", {63'h0, wdog_irq[1]}, 64'h0);
        evt_wdog[0] = 1'b1; step();
        check("R7 request pulse", {62'h0, wdog_rst_kind[0], wdog_rst_req[0]}, {62'h0, 2'b10, 1'b1});
        read_thr(0, v); check("R7 kind recorded", v, B_ARM | B_IRQ | (64'h2 << 28));
        step();
        check("R7 pulse one cycle", {63'h0, wdog_rst_req[0]}, 64'h0);
        wdog_rst_cfg[0] = 2'b11;
        evt_wdog[0] = 1'b1; step();
        check("R7 second request kind 3", {62'h0, wdog_rst_kind[0], wdog_rst_req[0]}, {62'h0, 2'b11, 1'b1});
        read_thr(0, v); check("R7 first kind kept", v, B_ARM | B_IRQ | (64'h2 << 28));
        clear_thr(0, '1);
        read_thr(0, v); check("R4 wdog bits cleared", v, 64'h0);
        wdog_rst_cfg[0] = 2'b00;
        evt_wdog[0] = 1'b1; step();
        evt_wdog[0] = 1'b1; step();
        evt_wdog[0] = 1'b1; step();
        check("R7 kind none no request", {63'h0, wdog_rst_req[0]}, 64'h0);
        read_thr(0, v); check("R7 kind none not recorded", v, B_ARM | B_IRQ);
        guest_en[0] = 1'b0;
        clear_thr(0, '1);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        evt_dec[0] = 1'b1; sw_sel = '0; sw_wr = 1'b1; sw_clr_mask = B_DEC; step();
        read_thr(0, v); check("R9 set beats clear", v, B_DEC);
        evt_wdog[0] = 1'b1; sw_sel = '0; sw_wr = 1'b1; sw_clr_mask = B_DEC | B_ARM; step();
        read_thr(0, v); check("R9 arm set with clear", v, B_ARM);
        clear_thr(0, '1);
    endtask

    task automatic t_threads();
        logic [63:0] v;
        wdog_rst_cfg[1] = 2'b01;
        evt_wdog[1] = 1'b1; evt_fit[1] = 1'b1; step();
        evt_wdog[1] = 1'b1; step();
        evt_wdog[1] = 1'b1; step();
        check("R10 thread1 request", {60'h0, wdog_rst_kind, wdog_rst_req}, {60'h0, 2'b01, 2'b00, 2'b10});
        read_thr(1, v); check("R10 thread1 word", v, B_ARM | B_IRQ | (64'h1 << 28) | B_FIT);
        read_thr(0, v); check("R10 thread0 untouched", v, 64'h0);
        evt_dec[0] = 1'b1; step();
        clear_thr(1, '1);
        read_thr(0, v); check("R10 write to thread1 spares thread0", v, B_DEC);
        read_thr(1, v); check("R10 thread1 cleared", v, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_mask();
        t_wdog();
        t_collide();
        t_threads();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule